// File: doc/BRIEF.md
# Byte-Wide State Scan Port

The scan port lets software save and later restore the internal state of a legacy sound engine across suspend and resume. The engine exposes its 218 state flip-flops as one parallel vector. The port treats that vector as an ordered chain. Software reads or writes the chain one byte at a time through a single data register.

A byte pointer walks the chain automatically. Before a readout starts, the port freezes a snapshot of the engine state, so the saved image stays self-consistent even while the engine keeps running. On restore, software writes the bytes in the same order. After the final byte, the port presents the rebuilt vector to the engine together with a single-cycle load strobe.

The register bus uses plain strobes. It has two ports: an index port that selects a register, and a data port that reaches the selected register. Every access completes in the cycle of its strobe, so there is no back-pressure. Read data appears on `bus_rdata` one cycle after the read strobe and holds until the next read.

Top module: `scan_port`

## Requirements
- R1: After reset, `bus_rdata`, the selected index, the byte pointer, `restore_out` and `restore_load` are all zero.
- R2: A data-port read while index F1h is selected returns byte k of the chain, where k is the pointer value. Bit 0 of that byte is chain bit 8k and bit 7 is chain bit 8k+7.
- R3: Each data-port read or write at index F1h advances the pointer by one. After byte 27 the pointer wraps back to 0.
- R4: The pointer returns to 0 on any write to the index port and on `eng_rst`.
- R5: Read data comes from a copy of `state_in` taken at the first F1h access after the pointer reached 0. Later changes on `state_in` do not show until the pointer returns to 0 again.
- R6: In byte 27, bits 1:0 carry chain bits 217:216, and bits 7:2 read as zero.
- R7: A data-port write at index F1h stores `bus_wdata` into byte k of `restore_out`, where k is the pointer value. Bits 7:2 written to byte 27 have no effect.
- R8: `restore_load` is high for exactly one cycle: the cycle after the write of byte 27. It is never high at any other time.
- R9: A data-port read at index F8h returns 0000000 followed by `eng_irq` in bit 0.
- R10: Index-port reads, and data-port accesses at any index other than F1h, leave the pointer unchanged.
- R11: `bus_rdata` changes only in the cycle after a read strobe.
- R12: An index-port read returns the index last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| eng_rst | input | 1 | Engine reset; clears the byte pointer |
| bus_port | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one cycle after `bus_rd` |
| state_in | input | 218 | Live engine state chain |
| eng_irq | input | 1 | Engine interrupt flag |
| restore_out | output | 218 | Rebuilt state vector for the engine |
| restore_load | output | 1 | One-cycle strobe to load `restore_out` |

## Verification
A full readout is performed with `state_in` switched to a different pattern right after the first byte. This separates a snapshot read from a live read, and byte 27 exposes the masking of bits 7:2. A 29th read recaptures the new pattern, which shows the wrap to byte 0 and a fresh capture. A partial readout interrupted by index-port reads and then by `eng_rst` tells apart the accesses that advance the pointer from those that clear it. A full restore sends byte 27 with its upper bits set, which tests both the ignored bits and the exact cycle of the load strobe.

// File: rtl/scan_pkg.sv
package scan_pkg;
  // number of bus-wide bytes needed to cover a chain of cw bits
  function automatic int unsigned byte_count(input int unsigned cw, input int unsigned dw);
    return (cw + dw - 1) / dw;
  endfunction

  // pointer width for n bytes (at least one bit)
  function automatic int unsigned ptr_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/scan_ptr.sv
module scan_ptr #(
  parameter int unsigned NB = 28,
  parameter int unsigned PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  output logic [PW-1:0] ptr,
  output logic          fresh,
  output logic          at_last
);
  assign at_last = (ptr == PW'(NB - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      fresh <= 1'b1;
    end else if (clear) begin
      ptr   <= '0;
      fresh <= 1'b1;
    end else if (step) begin
      if (at_last) begin
        ptr   <= '0;
        fresh <= 1'b1;
      end else begin
        ptr   <= ptr + 1'b1;
        fresh <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/scan_snap.sv
module scan_snap #(
  parameter int unsigned CW = 218
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [CW-1:0] live,
  output logic [CW-1:0] held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held <= '0;
    else if (capture) held <= live;
  end
endmodule

// File: rtl/scan_asm.sv
module scan_asm #(
  parameter int unsigned CW = 218,
  parameter int unsigned DW = 8,
  parameter int unsigned NB = 28,
  parameter int unsigned PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          at_last,
  input  logic [PW-1:0] ptr,
  input  logic [DW-1:0] wdata,
  output logic [CW-1:0] image,
  output logic          load
);
  for (genvar k = 0; k < NB; k++) begin : g_seg
    localparam int unsigned LO = k * DW;
    localparam int unsigned SW = ((CW - LO) < DW) ? (CW - LO) : DW;
    logic [SW-1:0] seg;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          seg <= '0;
      else if (wr_en && ptr == PW'(k))     seg <= wdata[SW-1:0];
    end
    assign image[LO +: SW] = seg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load <= 1'b0;
    else        load <= wr_en && at_last;
  end
endmodule

// File: rtl/scan_port.sv
module scan_port #(
  parameter int unsigned CHAIN_W  = 218,
  parameter int unsigned DW       = 8,
  parameter logic [7:0]  IDX_SCAN = 8'hF1,
  parameter logic [7:0]  IDX_FLAG = 8'hF8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               eng_rst,
  input  logic               bus_port,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  input  logic [CHAIN_W-1:0] state_in,
  input  logic               eng_irq,
  output logic [CHAIN_W-1:0] restore_out,
  output logic               restore_load
);
  import scan_pkg::*;

  localparam int unsigned NB   = byte_count(CHAIN_W, DW);
  localparam int unsigned PW   = ptr_width(NB);
  localparam int unsigned PADW = NB * DW;

  logic [DW-1:0]      idx_q;
  logic [PW-1:0]      ptr_q;
  logic               fresh, at_last;
  logic [CHAIN_W-1:0] snap_q, src;
  logic [PADW-1:0]    padded;
  logic [DW-1:0]      sel_byte, rd_next;
  logic               idx_wr, data_hit, step, clear, wr_en;

  assign idx_wr   = bus_wr && !bus_port;
  assign data_hit = bus_port && (idx_q == DW'(IDX_SCAN));
  assign clear    = eng_rst || idx_wr;
  assign step     = data_hit && (bus_rd || bus_wr);
  assign wr_en    = data_hit && bus_wr && !eng_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_wr) idx_q <= bus_wdata;
  end

  scan_ptr #(.NB(NB), .PW(PW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clear(clear), .step(step),
    .ptr(ptr_q), .fresh(fresh), .at_last(at_last)
  );

  scan_snap #(.CW(CHAIN_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .capture(step && fresh && !clear),
    .live(state_in), .held(snap_q)
  );

  scan_asm #(.CW(CHAIN_W), .DW(DW), .NB(NB), .PW(PW)) u_asm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .at_last(at_last),
    .ptr(ptr_q), .wdata(bus_wdata), .image(restore_out), .load(restore_load)
  );

  // first access after a clear reads live state, later ones the snapshot
  assign src      = fresh ? state_in : snap_q;
  assign padded   = PADW'(src);
  assign sel_byte = padded[int'(ptr_q) * DW +: DW];

  always_comb begin
    if (!bus_port)                    rd_next = idx_q;
    else if (idx_q == DW'(IDX_SCAN))  rd_next = sel_byte;
    else if (idx_q == DW'(IDX_FLAG))  rd_next = DW'(eng_irq);
    else                              rd_next = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end
endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk #(
  parameter int unsigned DW       = 8,
  parameter int unsigned NB       = 28,
  parameter int unsigned PW       = 5,
  parameter logic [7:0]  IDX_SCAN = 8'hF1,
  parameter logic [7:0]  IDX_FLAG = 8'hF8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          eng_rst,
  input logic          bus_port,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [DW-1:0] bus_rdata,
  input logic          eng_irq,
  input logic          restore_load,
  input logic [PW-1:0] ptr,
  input logic [DW-1:0] idx
);
  p_ptr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PW'(NB - 1));

  p_ptr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_rst || (bus_wr && !bus_port)) |=> ptr == '0);

  p_ptr_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_rst && !(bus_wr && !bus_port) &&
     !(bus_port && idx == DW'(IDX_SCAN) && (bus_rd || bus_wr))) |=> $stable(ptr));

  p_load_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restore_load |=> !restore_load);

  p_load_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restore_load |-> $past(bus_port && bus_wr && !eng_rst &&
                           idx == DW'(IDX_SCAN) && ptr == PW'(NB - 1)));

  p_flag_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_port && bus_rd && idx == DW'(IDX_FLAG)) |=> bus_rdata == DW'($past(eng_irq)));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind scan_port scan_port_chk #(
  .DW(DW), .NB(NB), .PW(PW), .IDX_SCAN(IDX_SCAN), .IDX_FLAG(IDX_FLAG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .eng_rst(eng_rst), .bus_port(bus_port),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .eng_irq(eng_irq),
  .restore_load(restore_load), .ptr(ptr_q), .idx(idx_q)
);

// File: tb/test_scan_port.sv
`timescale 1ns/1ps
module test_scan_port;
  localparam int CW = 218;
  localparam int NB = 28;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          eng_rst = 1'b0;
  logic          bus_port = 1'b0;
  logic          bus_rd = 1'b0;
  logic          bus_wr = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [CW-1:0] state_in = '0;
  logic          eng_irq = 1'b0;
  logic [CW-1:0] restore_out;
  logic          restore_load;

  int checks = 0;
  int fails  = 0;
  int loads  = 0;
  logic rd_seen = 1'b0;
  logic [7:0] exp_q[$];
  string      req_q[$];

  always #5 clk = ~clk;

  scan_port i_scan_port (
    .clk(clk), .rst_n(rst_n), .eng_rst(eng_rst), .bus_port(bus_port),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .state_in(state_in), .eng_irq(eng_irq), .restore_out(restore_out),
    .restore_load(restore_load)
  );

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] mk(input int s);
    logic [CW-1:0] v;
    for (int i = 0; i < CW; i++) v[i] = (((i * s) + (i >> 2)) % 7) < 3;
    return v;
  endfunction

  function automatic logic [7:0] byte_of(input logic [CW-1:0] v, input int k);
    logic [NB*8-1:0] p;
    p = '0;
    p[CW-1:0] = v;
    return p[k*8 +: 8];
  endfunction

  // monitor: compare each read result the cycle after its strobe
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (restore_load) loads++;
    if (rd_seen) begin
      if (exp_q.size() == 0) check("R11", 1, 0);
      else check(req_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic rd(input logic port, input logic [7:0] exp, input string req);
    @(negedge clk);
    bus_port = port; bus_rd = 1'b1;
    exp_q.push_back(exp); req_q.push_back(req);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic port, input logic [7:0] d);
    @(negedge clk);
    bus_port = port; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [CW-1:0] a, b, c, w;
    logic [7:0] d;
    a = mk(5); b = mk(11); c = mk(3); w = mk(13);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", bus_rdata, 0);
    check("R1", restore_load, 0);
    check("R1", restore_out, 0);
    rd(1'b0, 8'h00, "R1 R12");

    // full readout; live state changes after first byte (snapshot)
    state_in = a;
    wr(1'b0, 8'hF1);
    rd(1'b0, 8'hF1, "R12");
    for (int k = 0; k < NB; k++) begin
      rd(1'b1, byte_of(a, k), (k == NB-1) ? "R6" : ((k == 0) ? "R2" : "R5"));
      if (k == 0) state_in = b;
    end
    // wrap to byte 0 with a fresh capture
    rd(1'b1, byte_of(b, 0), "R3");
    rd(1'b1, byte_of(b, 1), "R3");

    // partial readout, index reads do not advance, engine reset clears
    wr(1'b0, 8'hF1);
    state_in = c;
    for (int k = 0; k < 3; k++) rd(1'b1, byte_of(c, k), "R2");
    rd(1'b0, 8'hF1, "R10");
    rd(1'b0, 8'hF1, "R10");
    rd(1'b1, byte_of(c, 3), "R10");
    @(negedge clk); eng_rst = 1'b1;
    @(negedge clk); eng_rst = 1'b0;
    state_in = a;
    rd(1'b1, byte_of(a, 0), "R4");
    rd(1'b1, byte_of(a, 1), "R4");
    wr(1'b0, 8'hF1);
    rd(1'b1, byte_of(a, 0), "R4");

    // interrupt flag register and read-data hold
    wr(1'b0, 8'hF8);
    eng_irq = 1'b1;
    rd(1'b1, 8'h01, "R9");
    eng_irq = 1'b0;
    repeat (3) @(negedge clk);
    check("R11", bus_rdata, 8'h01);
    rd(1'b1, 8'h00, "R9");

    // restore: 28 writes, upper bits of last byte set
    wr(1'b0, 8'hF1);
    for (int k = 0; k < NB; k++) begin
      d = byte_of(w, k);
      if (k == NB-1) d = d | 8'hFC;
      wr(1'b1, d);
      check("R8", restore_load, (k == NB-1));
    end
    check("R7", restore_out, w);
    @(negedge clk);
    check("R8", restore_load, 0);
    check("R8", loads, 1);

    repeat (2) @(negedge clk);
    check("R11", exp_q.size(), 0);
    finish_run();
  end
endmodule